// File: doc/BRIEF.md
# Half-Line Dirty Cache Clean Engine

This block holds the tag and data arrays of a set-associative write-back data cache and runs clean operations on them. Every line carries a valid flag and two dirty flags, one for the lower half of the line and one for the upper half. A processor-side word write that hits a valid line updates the stored word and, when write-back mode is on, marks the half that holds the word as dirty. A clean writes only the dirty halves back to memory as 32-bit bus writes. It charges an access cost for each half it writes and then clears both dirty flags of the line. The line keeps its valid flag.

A clean request names its target in one of three ways: by way and index, by a memory address looked up in the tags, or as a sweep over the whole cache. The requester sees plain `busy` and `done` pins. Write-back data leaves through a valid/ready port. While `bw_valid` is high and `bw_ready` is low, the engine holds the address and data unchanged. A transfer completes on any clock edge where both are high. The sink may stall for any number of cycles. The cost figure models the cycles those bus writes would take on the target memory. It is not the number of clock cycles the engine spends.

Top module: `clean_engine`

## Requirements
- R1: After reset, `busy`, `done` and `bw_valid` are 0, `clean_cycles` is 0, and no line is valid.
- R2: A `cpu_wr_en` write that hits a valid line stores `cpu_wr_data` at word `cpu_wr_addr[4:2]`. It sets the lower-half dirty flag for words 0 to 3 and the upper-half flag for words 4 to 7, and it does so only when `wb_mode` is 1. With `wb_mode` at 0 no flag changes.
- R3: A clean writes a half back only if that half's dirty flag is set, with the lower half before the upper half. Each half goes out as ascending 32-bit writes to the line base plus 4 times the word number, carrying the current word contents, with `bw_addr[1:0]` equal to 0.
- R4: Each half that is written back adds `(n + 3*s) << shift` to `clean_cycles`. Here `n = 2 + base[25:24]`, `s = 1 + base[27:26]`, `base` is the line base address, and `shift` is `clk_shift` captured when the request is accepted. `clean_cycles` is cleared when a request is accepted and keeps the request's total afterwards.
- R5: After a clean, both dirty flags of the line are 0 and the line stays valid. A second clean writes nothing and costs 0, and a later write-back-mode write hits the line again.
- R6: `req_op` = 0 cleans the line at way `req_way`, index `req_index`. A line that is invalid or has no dirty flag set produces no writes.
- R7: `req_op` = 1 looks up `req_addr`, using index bits [7:5] and tag bits [31:8], and cleans the matching line. A miss completes with no writes and a cost of 0.
- R8: `req_op` = 2 visits every line: way 0 to 3 in the outer loop and index 0 to 7 ascending in the inner loop. It skips invalid or clean lines and sums all costs into `clean_cycles`.
- R9: While `bw_valid` is 1 and `bw_ready` is 0, `bw_valid`, `bw_addr` and `bw_data` hold their values on the next cycle.
- R10: A request is accepted only when `busy` is 0 and `req_op` is not 3. `busy` is 1 from the next cycle until the operation ends. `done` is then a one-cycle pulse with `busy` already 0. `req_op` = 3 is ignored. `bw_valid` is 0 whenever `busy` is 0.
- R11: `tag_load_en` while idle marks the line at way `tag_load_way`, index `tag_load_addr[7:5]` as valid, with tag `tag_load_addr[31:8]`, and clears both of its dirty flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_mode | input | 1 | Write-back mode; processor writes mark halves dirty |
| clk_shift | input | 2 | Cost scaling shift, captured at request acceptance |
| tag_load_en | input | 1 | Install a tag (ignored while busy) |
| tag_load_way | input | 2 | Way for the tag install |
| tag_load_addr | input | 32 | Line address for the tag install |
| cpu_wr_en | input | 1 | Processor word write (ignored while busy) |
| cpu_wr_addr | input | 32 | Processor write address |
| cpu_wr_data | input | 32 | Processor write data |
| wb_mode_unused_none | input | 1 | Reserved tie-off, must be 0; has no effect |
| req_valid | input | 1 | Clean request strobe |
| req_op | input | 2 | 0 by way/index, 1 by address, 2 whole cache, 3 ignored |
| req_way | input | 2 | Way for op 0 |
| req_index | input | 3 | Index for op 0 |
| req_addr | input | 32 | Address for op 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| clean_cycles | output | 32 | Accumulated cost of the current or last request |
| bw_valid | output | 1 | Write-back word valid |
| bw_ready | input | 1 | Write-back sink ready |
| bw_addr | output | 32 | Write-back word address |
| bw_data | output | 32 | Write-back word data |

## Verification
The bench builds lines for every combination of dirty halves, in every way and across all sixteen cost regions and four shift values. It cleans them by way and by address, so a design that writes a clean half, reorders halves, charges a whole line instead of per half, or ignores the shift shows up as a wrong write list or a wrong cost. Each clean is repeated to catch dirty flags that are not cleared, and writes made with write-back mode off catch flags set in the wrong mode. A sweep under a pseudo-random stall pattern shows whether the way-major visiting order holds. The same stalls show whether data moves while stalled and whether lines are skipped. An address miss, an unloaded line, a tag reload over a dirty line and the ignored opcode each have to end with no bus traffic.

// File: rtl/clean_pkg.sv
package clean_pkg;
  typedef enum logic [1:0] {
    OP_BY_WAY  = 2'd0,
    OP_BY_ADDR = 2'd1,
    OP_ALL     = 2'd2,
    OP_NONE    = 2'd3
  } clean_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_CHECK,
    ST_WRITE,
    ST_FIN
  } eng_state_e;
endpackage

// File: rtl/clean_tags.sv
module clean_tags #(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_INDEX = 8,
  parameter int TAG_W     = 24,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int IDX_W    = $clog2(NUM_INDEX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [WAY_W-1:0] ld_way,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic             mark_en,
  input  logic [WAY_W-1:0] mark_way,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             mark_lo,
  input  logic             mark_hi,
  input  logic             clr_en,
  input  logic [WAY_W-1:0] clr_way,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [WAY_W-1:0] lk_way,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dlo,
  output logic             rd_dhi
);
  localparam int ENT = NUM_WAYS * NUM_INDEX;

  logic [TAG_W-1:0] tag_q [ENT];
  logic [ENT-1:0]   vld_q, dlo_q, dhi_q;

  // flag state: clear, then mark, then install (later wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else begin
      if (clr_en) begin
        dlo_q[{clr_way, clr_idx}] <= 1'b0;
        dhi_q[{clr_way, clr_idx}] <= 1'b0;
      end
      if (mark_en) begin
        if (mark_lo) dlo_q[{mark_way, mark_idx}] <= 1'b1;
        if (mark_hi) dhi_q[{mark_way, mark_idx}] <= 1'b1;
      end
      if (ld_en) begin
        vld_q[{ld_way, ld_idx}] <= 1'b1;
        dlo_q[{ld_way, ld_idx}] <= 1'b0;
        dhi_q[{ld_way, ld_idx}] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) tag_q[{ld_way, ld_idx}] <= ld_tag;
  end

  // tag compare across all ways, lowest matching way wins
  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (vld_q[{WAY_W'(w), lk_idx}] && (tag_q[{WAY_W'(w), lk_idx}] == lk_tag)) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(w);
      end
    end
  end

  assign rd_valid = vld_q[{rd_way, rd_idx}];
  assign rd_tag   = tag_q[{rd_way, rd_idx}];
  assign rd_dlo   = dlo_q[{rd_way, rd_idx}];
  assign rd_dhi   = dhi_q[{rd_way, rd_idx}];
endmodule

// File: rtl/clean_data.sv
module clean_data #(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_INDEX = 8,
  parameter int WPL       = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int IDX_W    = $clog2(NUM_INDEX),
  localparam int WORD_W   = $clog2(WPL)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WAY_W-1:0]  w_way,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WORD_W-1:0] w_word,
  input  logic [31:0]       w_data,
  input  logic [WAY_W-1:0]  r_way,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [WORD_W-1:0] r_word,
  output logic [31:0]       r_data
);
  localparam int DEPTH = NUM_WAYS * NUM_INDEX * WPL;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_way, w_idx, w_word}] <= w_data;
  end

  assign r_data = mem[{r_way, r_idx, r_word}];
endmodule

// File: rtl/clean_timing.sv
module clean_timing #(
  parameter int LINE_BYTES = 32,
  parameter int COST_W     = 32,
  parameter int SHIFT_W    = 2
) (
  input  logic [31:0]        line_addr,
  input  logic [SHIFT_W-1:0] shift,
  output logic [COST_W-1:0]  half_cost
);
  localparam int SEQ_N = LINE_BYTES / 8 - 1;

  logic [3:0]        region;
  logic [COST_W-1:0] n_cost, s_cost, base_cost;

  // region-dependent access costs, computed rather than stored
  always_comb begin
    region    = line_addr[27:24];
    n_cost    = COST_W'(2) + COST_W'(region[1:0]);
    s_cost    = COST_W'(1) + COST_W'(region[3:2]);
    base_cost = n_cost + COST_W'(SEQ_N) * s_cost;
    half_cost = base_cost << shift;
  end
endmodule

// File: rtl/clean_engine.sv
module clean_engine
  import clean_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int NUM_INDEX  = 8,
  parameter int LINE_BYTES = 32,
  parameter int COST_W     = 32,
  parameter int SHIFT_W    = 2,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int IDX_W     = $clog2(NUM_INDEX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic [SHIFT_W-1:0] clk_shift,
  input  logic              tag_load_en,
  input  logic [WAY_W-1:0]  tag_load_way,
  input  logic [31:0]       tag_load_addr,
  input  logic              cpu_wr_en,
  input  logic [31:0]       cpu_wr_addr,
  input  logic [31:0]       cpu_wr_data,
  input  logic              wb_mode_unused_none,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [31:0]       req_addr,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] clean_cycles,
  output logic              bw_valid,
  input  logic              bw_ready,
  output logic [31:0]       bw_addr,
  output logic [31:0]       bw_data
);
  localparam int WPL    = LINE_BYTES / 4;
  localparam int HALF   = WPL / 2;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WORD_W = $clog2(WPL);
  localparam int TAG_W  = 32 - OFF_W - IDX_W;

  eng_state_e        state_q;
  clean_op_e         op_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [WAY_W-1:0]  cur_way;
  logic [IDX_W-1:0]  cur_idx;
  logic [31:0]       addr_q;
  logic [WORD_W-1:0] word_q;
  logic [COST_W-1:0] cost_q;
  logic              done_q;

  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              rd_valid, rd_dlo, rd_dhi;
  logic [TAG_W-1:0]  rd_tag;
  logic [31:0]       rd_data;
  logic [COST_W-1:0] half_cost;
  logic [31:0]       line_base;
  logic              cpu_hit, ld_ok, req_fire;
  logic [WORD_W-1:0] cpu_word;
  logic              last_lo, last_hi, last_line;

  assign busy = (state_q != ST_IDLE);

  // one lookup port, shared by the engine and the processor write path
  assign lk_idx  = busy ? addr_q[OFF_W +: IDX_W] : cpu_wr_addr[OFF_W +: IDX_W];
  assign lk_tag  = busy ? addr_q[31 -: TAG_W]    : cpu_wr_addr[31 -: TAG_W];

  assign cpu_word = cpu_wr_addr[OFF_W-1:2];
  assign cpu_hit  = cpu_wr_en && !busy && lk_hit;
  assign ld_ok    = tag_load_en && !busy;
  assign req_fire = req_valid && !busy && (req_op != OP_NONE);

  assign line_base = {rd_tag, cur_idx, {OFF_W{1'b0}}};
  assign last_lo   = (word_q == WORD_W'(HALF - 1));
  assign last_hi   = (word_q == WORD_W'(WPL - 1));
  assign last_line = (cur_way == WAY_W'(NUM_WAYS - 1)) && (cur_idx == IDX_W'(NUM_INDEX - 1));

  clean_tags #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_INDEX(NUM_INDEX),
    .TAG_W    (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_ok),
    .ld_way  (tag_load_way),
    .ld_idx  (tag_load_addr[OFF_W +: IDX_W]),
    .ld_tag  (tag_load_addr[31 -: TAG_W]),
    .mark_en (cpu_hit && wb_mode),
    .mark_way(lk_way),
    .mark_idx(lk_idx),
    .mark_lo (cpu_word < WORD_W'(HALF)),
    .mark_hi (cpu_word >= WORD_W'(HALF)),
    .clr_en  (state_q == ST_FIN),
    .clr_way (cur_way),
    .clr_idx (cur_idx),
    .lk_idx  (lk_idx),
    .lk_tag  (lk_tag),
    .lk_hit  (lk_hit),
    .lk_way  (lk_way),
    .rd_way  (cur_way),
    .rd_idx  (cur_idx),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_dlo  (rd_dlo),
    .rd_dhi  (rd_dhi)
  );

  clean_data #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_INDEX(NUM_INDEX),
    .WPL      (WPL)
  ) u_data (
    .clk   (clk),
    .we    (cpu_hit),
    .w_way (lk_way),
    .w_idx (lk_idx),
    .w_word(cpu_word),
    .w_data(cpu_wr_data),
    .r_way (cur_way),
    .r_idx (cur_idx),
    .r_word(word_q),
    .r_data(rd_data)
  );

  clean_timing #(
    .LINE_BYTES(LINE_BYTES),
    .COST_W    (COST_W),
    .SHIFT_W   (SHIFT_W)
  ) u_timing (
    .line_addr(line_base),
    .shift    (shift_q),
    .half_cost(half_cost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_BY_WAY;
      shift_q <= '0;
      cur_way <= '0;
      cur_idx <= '0;
      addr_q  <= '0;
      word_q  <= '0;
      cost_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            op_q    <= clean_op_e'(req_op);
            shift_q <= clk_shift;
            cost_q  <= '0;
            addr_q  <= req_addr;
            cur_way <= (req_op == OP_ALL) ? '0 : req_way;
            cur_idx <= (req_op == OP_ALL) ? '0 : req_index;
            state_q <= (req_op == OP_BY_ADDR) ? ST_LOOK : ST_CHECK;
          end
        end
        ST_LOOK: begin
          if (lk_hit) begin
            cur_way <= lk_way;
            cur_idx <= addr_q[OFF_W +: IDX_W];
            state_q <= ST_CHECK;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_CHECK: begin
          if (rd_valid && (rd_dlo || rd_dhi)) begin
            word_q  <= rd_dlo ? '0 : WORD_W'(HALF);
            state_q <= ST_WRITE;
          end else begin
            state_q <= ST_FIN;
          end
        end
        ST_WRITE: begin
          if (bw_ready) begin
            if (last_lo || last_hi) cost_q <= cost_q + half_cost;
            if (last_hi || (last_lo && !rd_dhi)) state_q <= ST_FIN;
            else word_q <= word_q + 1'b1;
          end
        end
        ST_FIN: begin
          if ((op_q == OP_ALL) && !last_line) begin
            if (cur_idx == IDX_W'(NUM_INDEX - 1)) begin
              cur_idx <= '0;
              cur_way <= cur_way + 1'b1;
            end else begin
              cur_idx <= cur_idx + 1'b1;
            end
            state_q <= ST_CHECK;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done         = done_q;
  assign clean_cycles = cost_q;
  assign bw_valid     = (state_q == ST_WRITE);
  assign bw_addr      = {rd_tag, cur_idx, word_q, 2'b00};
  assign bw_data      = rd_data;

  logic unused_tie;
  assign unused_tie = wb_mode_unused_none;
endmodule

module clean_engine_chk #(
  parameter int COST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              busy,
  input logic              done,
  input logic [COST_W-1:0] clean_cycles,
  input logic              bw_valid,
  input logic              bw_ready,
  input logic [31:0]       bw_addr,
  input logic [31:0]       bw_data
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid && !bw_ready |=> bw_valid && $stable(bw_addr) && $stable(bw_data));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bw_valid);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && (req_op != 2'd3) |=> busy);

  assert_ignore_op3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(req_valid && (req_op != 2'd3)) |=> !busy);

  assert_word_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid |-> (bw_addr[1:0] == 2'b00));

  assert_cost_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (clean_cycles == '0));
endmodule

bind clean_engine clean_engine_chk #(.COST_W(COST_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .busy        (busy),
  .done        (done),
  .clean_cycles(clean_cycles),
  .bw_valid    (bw_valid),
  .bw_ready    (bw_ready),
  .bw_addr     (bw_addr),
  .bw_data     (bw_data)
);

// File: tb/tb_clean_engine.sv
`timescale 1ns/1ps
module tb_clean_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b0;
  logic [1:0]  clk_shift = '0;
  logic        tag_load_en = 1'b0;
  logic [1:0]  tag_load_way = '0;
  logic [31:0] tag_load_addr = '0;
  logic        cpu_wr_en = 1'b0;
  logic [31:0] cpu_wr_addr = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_way = '0;
  logic [2:0]  req_index = '0;
  logic [31:0] req_addr = '0;
  logic        busy, done, bw_valid;
  logic        bw_ready = 1'b1;
  logic [31:0] clean_cycles, bw_addr, bw_data;

  always #4 clk = ~clk;

  clean_engine dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .clk_shift(clk_shift),
    .tag_load_en(tag_load_en), .tag_load_way(tag_load_way), .tag_load_addr(tag_load_addr),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .wb_mode_unused_none(1'b0),
    .req_valid(req_valid), .req_op(req_op), .req_way(req_way), .req_index(req_index),
    .req_addr(req_addr), .busy(busy), .done(done), .clean_cycles(clean_cycles),
    .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr), .bw_data(bw_data)
  );

  int tests = 0;
  int fails = 0;

  // bench-side model of the cache contents
  bit          m_v  [4][8];
  bit          m_lo [4][8];
  bit          m_hi [4][8];
  logic [31:0] m_base [4][8];
  logic [31:0] m_data [4][8][8];

  logic [31:0] exp_addr [512];
  logic [31:0] exp_data [512];
  int          n_exp;
  logic [31:0] exp_cost;
  logic [31:0] log_addr [512];
  logic [31:0] log_data [512];
  int          n_log = 0;
  bit          stall_mode = 1'b0;
  logic [7:0]  lfsr = 8'h5B;

  // sink: choose ready, then record a transfer that will happen at the next edge
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bw_ready = stall_mode ? lfsr[0] : 1'b1;
    if (bw_valid && bw_ready && n_log < 512) begin
      log_addr[n_log] = bw_addr;
      log_data[n_log] = bw_data;
      n_log++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] half_cost(input logic [31:0] base, input int sh);
    int n, s;
    n = 2 + int'(base[25:24]);
    s = 1 + int'(base[27:26]);
    return 32'((n + 3 * s) << sh);
  endfunction

  task automatic cpu_write(input int w, input int i, input int k,
                           input logic [31:0] d, input bit wb);
    cpu_wr_en = 1'b1;
    cpu_wr_addr = m_base[w][i] + 32'(4 * k);
    cpu_wr_data = d;
    wb_mode = wb;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    wb_mode = 1'b0;
    m_data[w][i][k] = d;
    if (wb) begin
      if (k < 4) m_lo[w][i] = 1'b1;
      else       m_hi[w][i] = 1'b1;
    end
  endtask

  task automatic load_line(input int w, input int i, input logic [31:0] base);
    tag_load_en = 1'b1;
    tag_load_way = 2'(w);
    tag_load_addr = base;
    @(negedge clk);
    tag_load_en = 1'b0;
    m_v[w][i] = 1'b1;
    m_lo[w][i] = 1'b0;
    m_hi[w][i] = 1'b0;
    m_base[w][i] = base;
    for (int k = 0; k < 8; k++)
      cpu_write(w, i, k, base ^ (32'(k) * 32'h0101_0101) ^ 32'h5A00_0000, 1'b0);
  endtask

  task automatic exp_clear();
    n_exp = 0;
    exp_cost = '0;
  endtask

  // append the expected writes of one line, then mark it clean in the model
  task automatic exp_line(input int w, input int i, input int sh);
    if (m_v[w][i]) begin
      for (int h = 0; h < 2; h++) begin
        if ((h == 0 && m_lo[w][i]) || (h == 1 && m_hi[w][i])) begin
          for (int k = h * 4; k < h * 4 + 4; k++) begin
            exp_addr[n_exp] = m_base[w][i] + 32'(4 * k);
            exp_data[n_exp] = m_data[w][i][k];
            n_exp++;
          end
          exp_cost = exp_cost + half_cost(m_base[w][i], sh);
        end
      end
      m_lo[w][i] = 1'b0;
      m_hi[w][i] = 1'b0;
    end
  endtask

  task automatic run_req(input int op, input int w, input int i, input logic [31:0] a,
                         input int sh, input string req);
    int cnt;
    int bad;
    n_log = 0;
    req_valid = 1'b1;
    req_op = 2'(op);
    req_way = 2'(w);
    req_index = 3'(i);
    req_addr = a;
    clk_shift = 2'(sh);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done == 1'b1, "R10", "done pulse seen", 32'(done), 32'd1);
    chk(busy == 1'b0, "R10", "busy low at done", 32'(busy), 32'd0);
    chk(n_log == n_exp, req, "write count", 32'(n_log), 32'(n_exp));
    bad = -1;
    for (int j = 0; j < n_exp && j < n_log; j++)
      if (bad < 0 && (log_addr[j] !== exp_addr[j] || log_data[j] !== exp_data[j])) bad = j;
    if (bad >= 0)
      chk(1'b0, req, "write addr/data", log_addr[bad] ^ log_data[bad],
          exp_addr[bad] ^ exp_data[bad]);
    else
      chk(1'b1, req, "write addr/data", '0, '0);
    chk(clean_cycles == exp_cost, "R4", "clean cost", clean_cycles, exp_cost);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done at reset", {30'd0, busy, done}, '0);
    chk(bw_valid == 1'b0, "R1", "bus idle at reset", 32'(bw_valid), '0);
    chk(clean_cycles == '0, "R1", "cost at reset", clean_cycles, '0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_clear();
    run_req(0, 0, 0, '0, 0, "R1");

    // R3 R4 R5 R6 R7: every dirty pattern in every way, all regions and shifts
    for (int pat = 0; pat < 4; pat++) begin
      for (int w = 0; w < 4; w++) begin
        a = (32'(pat * 4 + w) << 24) | (32'(w) << 12) | (32'(pat) << 5);
        stall_mode = pat[0];
        load_line(w, pat, a);
        if (pat[0]) cpu_write(w, pat, w, ~m_data[w][pat][w], 1'b1);
        if (pat[1]) cpu_write(w, pat, 4 + w, ~m_data[w][pat][4 + w], 1'b1);
        exp_clear();
        exp_line(w, pat, w);
        if (w % 2 == 0) run_req(0, w, pat, '0, w, "R3 R6");
        else            run_req(1, 0, 0, a + 32'd12, w, "R3 R7");
        exp_clear();
        run_req(0, w, pat, '0, w, "R5");
      end
    end

    // R5: line stays valid and can be made dirty again
    cpu_write(2, 1, 6, 32'hCAFE_0006, 1'b1);
    exp_clear();
    exp_line(2, 1, 3);
    run_req(1, 0, 0, m_base[2][1], 3, "R5");

    // R2: writes with write-back mode off leave no dirty half
    cpu_write(1, 3, 2, 32'h1234_5678, 1'b0);
    cpu_write(1, 3, 7, 32'h8765_4321, 1'b0);
    exp_clear();
    run_req(0, 1, 3, '0, 0, "R2");

    // R7: address miss
    exp_clear();
    run_req(1, 0, 0, 32'hF0F0_F060, 1, "R7");

    // R6: unloaded line
    exp_clear();
    run_req(0, 3, 7, '0, 2, "R6");

    // R11: reload over a dirty line clears its dirty flags
    cpu_write(0, 2, 1, 32'hDEAD_0001, 1'b1);
    load_line(0, 2, m_base[0][2]);
    exp_clear();
    run_req(0, 0, 2, '0, 0, "R11");

    // R10: opcode 3 is not accepted
    req_valid = 1'b1;
    req_op = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, "R10", "op 3 ignored", 32'(busy), '0);
    chk(bw_valid == 1'b0, "R10", "no bus after op 3", 32'(bw_valid), '0);

    // R8 R9: full sweep under stalls
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 4; i++) begin
        if ((w + i) % 4 == 1 || (w + i) % 4 == 3) cpu_write(w, i, i, 32'hA000_0000 + 32'(w * 16 + i), 1'b1);
        if ((w + i) % 4 >= 2) cpu_write(w, i, 4 + i, 32'hB000_0000 + 32'(w * 16 + i), 1'b1);
      end
    stall_mode = 1'b1;
    exp_clear();
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 8; i++) exp_line(w, i, 1);
    run_req(2, 0, 0, '0, 1, "R8 R9");
    exp_clear();
    run_req(2, 0, 0, '0, 1, "R8 R5");
    stall_mode = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule